// File: doc/BRIEF.md
# Set/Clear Interrupt Register File

This block is the register front end of a level-sensitive interrupt controller with up to three banks of 32 lines. It sits on a simple 32-bit register bus with address, write enable, write data and combinational read data. For each bank it stores a mask, a software-interrupt vector, the pending state, and the last sampled level of the request inputs. For each line it stores a 6-bit priority and a class bit that steers the line to the IRQ or the FIQ output. The sorter and capture logic downstream receive this state on flat ports. They receive one-cycle strobes that ask for a priority re-evaluation or a re-arm of either output. They return the winning line codes, which software can read.

The mask and the software vector each have separate set and clear aliases. Writes to these aliases change pending state and request re-evaluation in different ways. Pending status is read back already split into an IRQ view and an FIQ view. The block also holds a global enable, a soft reset, two idle bits, an autoidle bit and fixed identification words.

Top module: `intc_setclr_regs`

## Requirements
- R1: After reset, and after a soft reset, every mask bit reads 1. Priority, class, software vector, pending, sampled inputs, autoidle and idle bits are all 0, and the global enable is 1.
- R2: Bank b (b below NBANK) owns byte addresses 0x80+0x20·b up to 0x9C. Offset 0x00 in the bank reads the request levels as sampled at the previous clock edge. Bank address groups with b at or above NBANK read 0, and writes to them are ignored. Banks do not affect each other.
- R3: A write to bank offset 0x04 replaces the mask, and `reeval_o` is high for the cycle after the write.
- R4: A write to offset 0x08 clears the written mask bits and pulses `reeval_o`. A write to offset 0x0C sets the written mask bits and does not pulse `reeval_o`. Both aliases read 0.
- R5: A write to offset 0x10 ORs the value into the software vector, then ORs the software vector into pending, and pulses `reeval_o`. A read of offset 0x10 returns the software vector.
- R6: A write to offset 0x14 clears the written bits of the software vector, then sets pending to the software vector AND the current request levels. This alias reads 0.
- R7: A request line that rises sets its pending bit. If any line of a bank falls, that bank's pending becomes its current levels OR its software vector.
- R8: Offset 0x18 reads pending AND NOT mask AND NOT class. Offset 0x1C reads pending AND NOT mask AND class, where a class bit of 1 means FIQ.
- R9: The line word at 0x100+0x80·b+4·l holds the priority in bits 7:2 and the class in bit 0. Bit 1 and bits 31:8 are discarded and read 0. The stored values appear on `prio_o` and `fiq_cls_o`.
- R10: A write to 0x48 with bit 2 set clears the global enable, and bit 2 clear sets it. Bit 2 reads back as the inverse of the enable. Writing bit 0 or bit 1 gives a one-cycle pulse on `rearm_irq_o` or `rearm_fiq_o` respectively.
- R11: In the word at 0x10, bit 0 stores autoidle and reads back. Writing bit 1 performs the soft reset of R1. The word at 0x50 stores two bits that read back.
- R12: Reads return 0x21 at 0x00, 1 at 0x14, the IRQ and FIQ winning codes at 0x40 and 0x44, and 0 at 0x4C. Writes to read-only words are ignored, and undecoded or unaligned addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Byte address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data |
| lvl_i | input | NBANK·32 | Level request inputs |
| win_irq_i | input | CODE_W | Winning IRQ line code from sorter |
| win_fiq_i | input | CODE_W | Winning FIQ line code from sorter |
| pend_o | output | NBANK·32 | Pending state per line |
| mask_o | output | NBANK·32 | Mask per line |
| fiq_cls_o | output | NBANK·32 | Class per line, 1 = FIQ |
| prio_o | output | NBANK·32·6 | Priority per line |
| glob_en_o | output | 1 | Global enable |
| rearm_irq_o | output | 1 | IRQ re-arm strobe |
| rearm_fiq_o | output | 1 | FIQ re-arm strobe |
| reeval_o | output | 1 | Re-evaluation request strobe |

## Verification
The assertions assume that `lvl_i` changes only between clock edges and that each write is a single-cycle strobe with its address and data stable around the edge. The bench drives every input on the falling clock edge and holds it for a full cycle, so both assumptions hold. The pending checks also assume that no other bank's request lines move during a bank's sequence. The stimulus therefore touches only the bank under test and returns its lines to 0 before moving on.

// File: rtl/intc_regs_pkg.sv
package intc_regs_pkg;
    localparam int REG_W  = 32;
    localparam int LINES  = 32;
    localparam int PRIO_W = 6;
    localparam int BANK_W = 2;
    localparam int LINE_W = $clog2(LINES);
    localparam int MAXBNK = 1 << BANK_W;

    typedef enum logic [4:0] {
        K_NONE, K_REV, K_SYSCFG, K_SYSSTAT, K_WIN_IRQ, K_WIN_FIQ, K_CTRL,
        K_PROT, K_IDLE, K_RAW, K_MASK, K_MASK_CLR, K_MASK_SET, K_SWI_SET,
        K_SWI_CLR, K_PEND_IRQ, K_PEND_FIQ, K_LINE
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e          kind;
        logic [BANK_W-1:0]  bank;
        logic [LINE_W-1:0]  line;
    } reg_sel_t;

    function automatic logic is_bank_kind(input reg_kind_e k);
        return k inside {K_RAW, K_MASK, K_MASK_CLR, K_MASK_SET,
                         K_SWI_SET, K_SWI_CLR, K_PEND_IRQ, K_PEND_FIQ};
    endfunction

    function automatic logic [REG_W-1:0] line_word(input logic [PRIO_W-1:0] p,
                                                   input logic cls);
        return {{(REG_W-PRIO_W-2){1'b0}}, p, 1'b0, cls};
    endfunction
endpackage

// File: rtl/intc_addr_dec.sv
module intc_addr_dec
    import intc_regs_pkg::*;
#(
    parameter int NBANK  = 3,
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_t          sel_o
);
    localparam int LINE_LO = 'h100;
    localparam int LINE_HI = LINE_LO + 'h80 * NBANK;

    logic [ADDR_W-1:0] loff;

    always_comb begin
        sel_o = '{kind: K_NONE, bank: '0, line: '0};
        loff  = addr_i - ADDR_W'(LINE_LO);
        if (addr_i[1:0] == 2'b00) begin
            if (int'(addr_i) >= 'h80 && int'(addr_i) < 'h100) begin
                if (int'(addr_i[6:5]) < NBANK) begin
                    sel_o.bank = addr_i[6:5];
                    case (addr_i[4:2])
                        3'd0: sel_o.kind = K_RAW;
                        3'd1: sel_o.kind = K_MASK;
                        3'd2: sel_o.kind = K_MASK_CLR;
                        3'd3: sel_o.kind = K_MASK_SET;
                        3'd4: sel_o.kind = K_SWI_SET;
                        3'd5: sel_o.kind = K_SWI_CLR;
                        3'd6: sel_o.kind = K_PEND_IRQ;
                        default: sel_o.kind = K_PEND_FIQ;
                    endcase
                end
            end else if (int'(addr_i) >= LINE_LO && int'(addr_i) < LINE_HI) begin
                sel_o.kind = K_LINE;
                sel_o.bank = loff[8:7];
                sel_o.line = addr_i[6:2];
            end else begin
                case (int'(addr_i))
                    'h00: sel_o.kind = K_REV;
                    'h10: sel_o.kind = K_SYSCFG;
                    'h14: sel_o.kind = K_SYSSTAT;
                    'h40: sel_o.kind = K_WIN_IRQ;
                    'h44: sel_o.kind = K_WIN_FIQ;
                    'h48: sel_o.kind = K_CTRL;
                    'h4C: sel_o.kind = K_PROT;
                    'h50: sel_o.kind = K_IDLE;
                    default: sel_o.kind = K_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/intc_bank_regs.sv
module intc_bank_regs
    import intc_regs_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [LINES-1:0] lvl_i,
    input  logic             wr_i,
    input  reg_kind_e        kind_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [LINES-1:0] raw_o,
    output logic [LINES-1:0] mask_o,
    output logic [LINES-1:0] swi_o,
    output logic [LINES-1:0] pend_o
);
    logic [LINES-1:0] raw_q, mask_q, swi_q, pend_q;
    logic [LINES-1:0] pend_lvl, pend_n, swi_n, mask_n;

    always_comb begin
        if ((raw_q & ~lvl_i) != '0) pend_lvl = lvl_i | swi_q;
        else                        pend_lvl = pend_q | (lvl_i & ~raw_q);
        pend_n = pend_lvl;
        swi_n  = swi_q;
        mask_n = mask_q;
        if (wr_i) begin
            case (kind_i)
                K_MASK:     mask_n = wdata_i;
                K_MASK_CLR: mask_n = mask_q & ~wdata_i;
                K_MASK_SET: mask_n = mask_q | wdata_i;
                K_SWI_SET: begin
                    swi_n  = swi_q | wdata_i;
                    pend_n = pend_lvl | swi_n;
                end
                K_SWI_CLR: begin
                    swi_n  = swi_q & ~wdata_i;
                    pend_n = swi_n & lvl_i;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            raw_q  <= '0;
            mask_q <= '1;
            swi_q  <= '0;
            pend_q <= '0;
        end else begin
            raw_q  <= lvl_i;
            mask_q <= mask_n;
            swi_q  <= swi_n;
            pend_q <= pend_n;
        end
    end

    assign raw_o  = raw_q;
    assign mask_o = mask_q;
    assign swi_o  = swi_q;
    assign pend_o = pend_q;

    assert_mask_set_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_i && kind_i == K_MASK_SET) |=> ((mask_o & $past(wdata_i)) == $past(wdata_i)));
    assert_mask_clr_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_i && kind_i == K_MASK_CLR) |=> ((mask_o & $past(wdata_i)) == '0));
    assert_swi_set_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_i && kind_i == K_SWI_SET) |=> ((pend_o & swi_o) == swi_o));
    assert_swi_clr_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_i && kind_i == K_SWI_CLR) |=> (pend_o == (swi_o & raw_o)));
endmodule

// File: rtl/intc_line_cfg.sv
module intc_line_cfg
    import intc_regs_pkg::*;
(
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    we_i,
    input  logic [LINE_W-1:0]       line_i,
    input  logic [PRIO_W-1:0]       prio_i,
    input  logic                    cls_i,
    output logic [REG_W-1:0]        rd_o,
    output logic [LINES*PRIO_W-1:0] prio_o,
    output logic [LINES-1:0]        cls_o
);
    logic [PRIO_W-1:0] prio_q [LINES];
    logic [LINES-1:0]  cls_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int i = 0; i < LINES; i++) prio_q[i] <= '0;
            cls_q <= '0;
        end else if (we_i) begin
            prio_q[line_i] <= prio_i;
            cls_q[line_i]  <= cls_i;
        end
    end

    for (genvar l = 0; l < LINES; l++) begin : g_flat
        assign prio_o[l*PRIO_W +: PRIO_W] = prio_q[l];
    end

    assign cls_o = cls_q;
    assign rd_o  = line_word(prio_q[line_i], cls_q[line_i]);

    assert_line_store_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        we_i |=> (prio_q[$past(line_i)] == $past(prio_i) && cls_q[$past(line_i)] == $past(cls_i)));
endmodule

// File: rtl/intc_setclr_regs.sv
module intc_setclr_regs
    import intc_regs_pkg::*;
#(
    parameter int NBANK  = 3,
    parameter int ADDR_W = 12,
    parameter int CODE_W = $clog2(NBANK * LINES)
) (
    input  logic                          clk_i,
    input  logic                          rst_i,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic                          we_i,
    input  logic [REG_W-1:0]              wdata_i,
    output logic [REG_W-1:0]              rdata_o,
    input  logic [NBANK*LINES-1:0]        lvl_i,
    input  logic [CODE_W-1:0]             win_irq_i,
    input  logic [CODE_W-1:0]             win_fiq_i,
    output logic [NBANK*LINES-1:0]        pend_o,
    output logic [NBANK*LINES-1:0]        mask_o,
    output logic [NBANK*LINES-1:0]        fiq_cls_o,
    output logic [NBANK*LINES*PRIO_W-1:0] prio_o,
    output logic                          glob_en_o,
    output logic                          rearm_irq_o,
    output logic                          rearm_fiq_o,
    output logic                          reeval_o
);
    reg_sel_t         sel;
    logic             srst;
    logic             glob_en_q, autoidle_q, rearm_irq_q, rearm_fiq_q, reeval_q;
    logic [1:0]       idle_q;
    logic [LINES-1:0] raw_a [MAXBNK];
    logic [LINES-1:0] mask_a [MAXBNK];
    logic [LINES-1:0] swi_a [MAXBNK];
    logic [LINES-1:0] pend_a [MAXBNK];
    logic [LINES-1:0] cls_a [MAXBNK];
    logic [REG_W-1:0] cfg_a [MAXBNK];

    intc_addr_dec #(.NBANK(NBANK), .ADDR_W(ADDR_W)) u_dec (
        .addr_i (addr_i),
        .sel_o  (sel)
    );

    assign srst = rst_i || (we_i && sel.kind == K_SYSCFG && wdata_i[1]);

    for (genvar b = 0; b < MAXBNK; b++) begin : g_bank
        if (b < NBANK) begin : g_live
            logic bank_wr, line_wr;
            assign bank_wr = we_i && is_bank_kind(sel.kind) && sel.bank == BANK_W'(b);
            assign line_wr = we_i && sel.kind == K_LINE && sel.bank == BANK_W'(b);

            intc_bank_regs u_bank (
                .clk_i   (clk_i),
                .rst_i   (srst),
                .lvl_i   (lvl_i[b*LINES +: LINES]),
                .wr_i    (bank_wr),
                .kind_i  (sel.kind),
                .wdata_i (wdata_i),
                .raw_o   (raw_a[b]),
                .mask_o  (mask_a[b]),
                .swi_o   (swi_a[b]),
                .pend_o  (pend_a[b])
            );

            intc_line_cfg u_cfg (
                .clk_i  (clk_i),
                .rst_i  (srst),
                .we_i   (line_wr),
                .line_i (sel.line),
                .prio_i (wdata_i[PRIO_W+1:2]),
                .cls_i  (wdata_i[0]),
                .rd_o   (cfg_a[b]),
                .prio_o (prio_o[b*LINES*PRIO_W +: LINES*PRIO_W]),
                .cls_o  (cls_a[b])
            );

            assign pend_o[b*LINES +: LINES]    = pend_a[b];
            assign mask_o[b*LINES +: LINES]    = mask_a[b];
            assign fiq_cls_o[b*LINES +: LINES] = cls_a[b];
        end else begin : g_void
            assign raw_a[b]  = '0;
            assign mask_a[b] = '0;
            assign swi_a[b]  = '0;
            assign pend_a[b] = '0;
            assign cls_a[b]  = '0;
            assign cfg_a[b]  = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (srst) begin
            glob_en_q   <= 1'b1;
            autoidle_q  <= 1'b0;
            idle_q      <= '0;
            rearm_irq_q <= 1'b0;
            rearm_fiq_q <= 1'b0;
            reeval_q    <= 1'b0;
        end else begin
            rearm_irq_q <= we_i && sel.kind == K_CTRL && wdata_i[0];
            rearm_fiq_q <= we_i && sel.kind == K_CTRL && wdata_i[1];
            reeval_q    <= we_i && (sel.kind inside {K_MASK, K_MASK_CLR, K_SWI_SET});
            if (we_i && sel.kind == K_CTRL)   glob_en_q  <= !wdata_i[2];
            if (we_i && sel.kind == K_SYSCFG) autoidle_q <= wdata_i[0];
            if (we_i && sel.kind == K_IDLE)   idle_q     <= wdata_i[1:0];
        end
    end

    always_comb begin
        case (sel.kind)
            K_REV:      rdata_o = 32'h21;
            K_SYSSTAT:  rdata_o = 32'h1;
            K_SYSCFG:   rdata_o = {31'b0, autoidle_q};
            K_WIN_IRQ:  rdata_o = REG_W'(win_irq_i);
            K_WIN_FIQ:  rdata_o = REG_W'(win_fiq_i);
            K_CTRL:     rdata_o = {29'b0, !glob_en_q, 2'b0};
            K_IDLE:     rdata_o = {30'b0, idle_q};
            K_RAW:      rdata_o = raw_a[sel.bank];
            K_MASK:     rdata_o = mask_a[sel.bank];
            K_SWI_SET:  rdata_o = swi_a[sel.bank];
            K_PEND_IRQ: rdata_o = pend_a[sel.bank] & ~mask_a[sel.bank] & ~cls_a[sel.bank];
            K_PEND_FIQ: rdata_o = pend_a[sel.bank] & ~mask_a[sel.bank] & cls_a[sel.bank];
            K_LINE:     rdata_o = cfg_a[sel.bank];
            default:    rdata_o = '0;
        endcase
    end

    assign glob_en_o   = glob_en_q;
    assign rearm_irq_o = rearm_irq_q;
    assign rearm_fiq_o = rearm_fiq_q;
    assign reeval_o    = reeval_q;

    assert_gmask_ctrl_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        (we_i && sel.kind == K_CTRL) |=> (glob_en_o == !$past(wdata_i[2])));
    assert_soft_reset_R11: assert property (@(posedge clk_i) disable iff (rst_i)
        (we_i && sel.kind == K_SYSCFG && wdata_i[1]) |=> (mask_o == '1 && pend_o == '0 && glob_en_o));
    assert_set_no_reeval_R4: assert property (@(posedge clk_i) disable iff (srst)
        (we_i && sel.kind == K_MASK_SET) |=> !reeval_o);
endmodule

// File: tb/tb_intc_setclr_regs.sv
`timescale 1ns/1ps
module tb_intc_setclr_regs;
    localparam int NB = 3;
    localparam int CW = $clog2(NB * 32);

    logic              clk = 1'b0;
    logic              rst;
    logic [11:0]       addr;
    logic              we;
    logic [31:0]       wdata;
    logic [31:0]       rdata;
    logic [NB*32-1:0]  lvl;
    logic [CW-1:0]     win_irq, win_fiq;
    logic [NB*32-1:0]  pend, mask, cls;
    logic [NB*32*6-1:0] prio;
    logic              glob_en, rearm_irq, rearm_fiq, reeval;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    intc_setclr_regs #(.NBANK(NB)) dut (
        .clk_i(clk), .rst_i(rst), .addr_i(addr), .we_i(we), .wdata_i(wdata),
        .rdata_o(rdata), .lvl_i(lvl), .win_irq_i(win_irq), .win_fiq_i(win_fiq),
        .pend_o(pend), .mask_o(mask), .fiq_cls_o(cls), .prio_o(prio),
        .glob_en_o(glob_en), .rearm_irq_o(rearm_irq), .rearm_fiq_o(rearm_fiq),
        .reeval_o(reeval)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; we = 1'b1;
        @(negedge clk); we = 1'b0; addr = 12'hFFC; wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk); addr = a; #1; v = rdata;
    endtask

    task automatic rdchk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic set_in(input int b, input logic [31:0] v);
        @(negedge clk); lvl[b*32 +: 32] = v;
        @(negedge clk);
    endtask

    logic [31:0] in_m, swi_m, pend_m, mask_m, cls_m;

    task automatic check_bank(input int b, input string req);
        logic [11:0] base;
        base = 12'(32'h80 + 32 * b);
        rdchk(req, base + 12'h00, in_m);
        rdchk(req, base + 12'h04, mask_m);
        rdchk(req, base + 12'h10, swi_m);
        rdchk(req, base + 12'h18, pend_m & ~mask_m & ~cls_m);
        rdchk(req, base + 12'h1C, pend_m & ~mask_m & cls_m);
        chk(req, pend[b*32 +: 32], pend_m);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] p, nv, s, v;
        logic [11:0] base;
        rst = 1'b1; we = 1'b0; addr = 12'hFFC; wdata = '0; lvl = '0;
        win_irq = CW'(7'h5A); win_fiq = CW'(7'h13);
        repeat (3) @(negedge clk);
        rst = 1'b0;

        chk("R1 glob_en", 32'(glob_en), 32'h1);
        rdchk("R1 ctrl", 12'h048, 32'h0);
        rdchk("R1 idle", 12'h050, 32'h0);

        for (int b = 0; b < NB; b++) begin
            base = 12'(32'h80 + 32 * b);
            in_m = '0; swi_m = '0; pend_m = '0; mask_m = '1; cls_m = '0;
            check_bank(b, "R1 R2 reset/isolation");

            for (int l = 0; l < 32; l++) begin
                p = 32'((l * 5 + b * 11) & 63);
                wr(12'(32'h100 + 32'h80 * b + 4 * l), (p << 2) | 32'(l & 1) | 32'h2 | 32'hFF00);
            end
            for (int l = 0; l < 32; l++) begin
                p = 32'((l * 5 + b * 11) & 63);
                rdchk("R9 line word", 12'(32'h100 + 32'h80 * b + 4 * l), (p << 2) | 32'(l & 1));
                chk("R9 prio port", 32'(prio[(b*32+l)*6 +: 6]), p);
            end
            cls_m = 32'hAAAAAAAA;
            chk("R9 class port", cls[b*32 +: 32], cls_m);

            p = 32'hA5A50000 ^ (32'h1111 * b);
            set_in(b, p); in_m = p; pend_m |= p;
            check_bank(b, "R7 R2 rise");

            wr(base + 12'h04, 32'h0F0F0F0F); mask_m = 32'h0F0F0F0F;
            chk("R3 reeval", 32'(reeval), 32'h1);
            check_bank(b, "R3 R8 mask write");

            wr(base + 12'h0C, 32'h000000F0); mask_m |= 32'h000000F0;
            chk("R4 set no reeval", 32'(reeval), 32'h0);
            rdchk("R4 set alias", base + 12'h0C, 32'h0);
            check_bank(b, "R4 mask set");

            wr(base + 12'h08, 32'hFFFF0000); mask_m &= ~32'hFFFF0000;
            chk("R4 clr reeval", 32'(reeval), 32'h1);
            rdchk("R4 clr alias", base + 12'h08, 32'h0);
            check_bank(b, "R4 R8 mask clear");

            s = 32'h00000300 | (32'(b) << 20);
            wr(base + 12'h10, s); swi_m |= s; pend_m |= swi_m;
            chk("R5 reeval", 32'(reeval), 32'h1);
            check_bank(b, "R5 swi set");

            nv = in_m & ~32'h80000000;
            set_in(b, nv); in_m = nv; pend_m = in_m | swi_m;
            check_bank(b, "R7 fall");

            wr(base + 12'h14, 32'h00000100); swi_m &= ~32'h00000100; pend_m = swi_m & in_m;
            rdchk("R6 clr alias", base + 12'h14, 32'h0);
            check_bank(b, "R6 swi clear");

            nv = in_m | 32'h2;
            set_in(b, nv); pend_m |= nv & ~in_m; in_m = nv;
            check_bank(b, "R7 rise after clear");

            set_in(b, 32'h0); in_m = '0; pend_m = swi_m;
            check_bank(b, "R7 all fall");
        end

        rdchk("R12 rev", 12'h000, 32'h21);
        rdchk("R12 status", 12'h014, 32'h1);
        rdchk("R12 protect", 12'h04C, 32'h0);
        rdchk("R12 win irq", 12'h040, 32'h5A);
        rdchk("R12 win fiq", 12'h044, 32'h13);
        wr(12'h000, 32'hDEADBEEF);
        rdchk("R12 ro write", 12'h000, 32'h21);
        wr(12'h014, 32'h0);
        rdchk("R12 ro status", 12'h014, 32'h1);
        rdchk("R12 undecoded", 12'h3FC, 32'h0);
        rdchk("R12 unaligned", 12'h085, 32'h0);
        wr(12'h0E4, 32'h0);
        rdchk("R2 bank3 read", 12'h0E4, 32'h0);
        rdchk("R2 bank3 line", 12'h280, 32'h0);
        chk("R2 bank3 no effect", mask[31:0], 32'hFFFF00F0 & ~32'hFFFF0000 | 32'h0F0F0F0F & ~32'hFFFF0000);

        wr(12'h048, 32'h4);
        chk("R10 gmask", 32'(glob_en), 32'h0);
        chk("R10 no rearm", 32'({rearm_irq, rearm_fiq}), 32'h0);
        rdchk("R10 ctrl read", 12'h048, 32'h4);
        wr(12'h048, 32'h1);
        chk("R10 rearm irq", 32'({rearm_irq, rearm_fiq, glob_en}), 32'h5);
        @(negedge clk);
        chk("R10 pulse width", 32'(rearm_irq), 32'h0);
        wr(12'h048, 32'h6);
        chk("R10 rearm fiq", 32'({rearm_irq, rearm_fiq, glob_en}), 32'h2);

        wr(12'h050, 32'hFFFFFFFF);
        rdchk("R11 idle", 12'h050, 32'h3);
        wr(12'h010, 32'h1);
        rdchk("R11 autoidle", 12'h010, 32'h1);

        wr(12'h010, 32'h2);
        rdchk("R11 R1 soft mask", 12'h0A4, 32'hFFFFFFFF);
        rdchk("R11 R1 soft swi", 12'h090, 32'h0);
        rdchk("R11 R1 soft line", 12'h114, 32'h0);
        rdchk("R11 R1 soft autoidle", 12'h010, 32'h0);
        rdchk("R11 R1 soft idle", 12'h050, 32'h0);
        rdchk("R11 R1 soft ctrl", 12'h048, 32'h0);
        chk("R11 R1 soft pend", 32'(pend != '0), 32'h0);
        chk("R11 R1 soft prio", 32'(prio != '0), 32'h0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule